// File: doc/BRIEF.md
# Reader interrupt status controller

This block gathers the interrupt causes of a contactless card reader front end and presents them to a host microcontroller. Single-cycle event pulses arrive from the transmitter, the receiver, the FIFO level monitor, the CRC, parity and framing checkers, the collision detector and the no-response timer. Each pulse sets a sticky flag in an 8-bit status register. One registered, active-high interrupt line goes to the host. The transmit and receive flags are set when a frame begins, but they only raise the interrupt once that frame has ended. The six other sources raise it only when their bit in a per-source enable mask is set.

The host reaches three byte registers through a simple read/write port. It issues read strobes, and it closes each read phase with an end-of-read pulse. The status register (0Ch) and the position fields clear themselves at the end of a read phase in which they were read. The register at 0Dh holds the two upper bits of a 10-bit collision/error bit position together with the six enable bits. The register at 0Eh holds the lower eight position bits. A write to the protocol control register, which lives elsewhere and is signalled here by a strobe, also wipes the status. When the enable input is low, the block holds every register at its default value.

Top module: `rdr_irq_ctrl`

## Requirements
- R1: Status register 0Ch reads, from bit 7 down to bit 0: TX, RX, FIFO, CRC error, parity error, framing/EOF error, collision, no-response. Each flag stays set until one of the clears in R7, R10 or R11 removes it.
- R2: `tx_start` or `tx_done` sets status bit 7. The interrupt for this bit is raised only after `tx_done` has been seen. The TX source has no enable bit.
- R3: `rx_sof` or `rx_done` sets status bit 6. The interrupt for this bit is raised only after `rx_done` has been seen. The RX source has no enable bit.
- R4: On a `fifo_upd` strobe, status bit 5 is set if `fifo_level` is below 4 or above 8. Levels 4 through 8 leave the bit unchanged.
- R5: Status bits 5..0 raise the interrupt only when the matching enable bit in 0Dh[5:0] is 1. The bits are matched one to one: FIFO 5, CRC 4, parity 3, framing 2, collision 1, no-response 0.
- R6: After reset, 0Dh reads 0x3E. A write to 0Dh changes only bits 5:0. Writes to 0Ch and 0Eh have no effect.
- R7: If 0Ch was read during a read phase, the status register becomes 0x00 on the `rd_end` edge and the interrupt falls on that same edge.
- R8: A `pos_vld` pulse loads `pos_bits`. Bits 9:8 appear in 0Dh[7:6] and bits 7:0 appear in 0Eh.
- R9: At `rd_end`, a read of 0Eh in that phase clears position bits 7:0. A read of 0Dh in that phase clears position bits 9:8. The enable bits keep their value.
- R10: A `ctrl_wr` pulse clears the status register and the interrupt on the next edge.
- R11: While `en` is low, the status, the interrupt and the position are 0 and the mask is 0x3E. Events and writes are ignored.
- R12: An event in the same cycle as a read clear or a `ctrl_wr` clear is kept.
- R13: The interrupt output is registered. It rises on the edge that stores a qualified flag and stays high while any qualified flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| en | input | 1 | Block enable; when low, all registers are held at their defaults |
| ctrl_wr | input | 1 | Pulse marking a write to the protocol control register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| rd_end | input | 1 | End of host read phase |
| tx_start | input | 1 | Transmission began |
| tx_done | input | 1 | Transmission finished |
| rx_sof | input | 1 | Start of frame received |
| rx_done | input | 1 | Reception finished |
| fifo_upd | input | 1 | FIFO level sample valid |
| fifo_level | input | 5 | FIFO byte count |
| crc_err | input | 1 | CRC error pulse |
| par_err | input | 1 | Parity error pulse |
| frm_err | input | 1 | Framing or EOF error pulse |
| col_err | input | 1 | Collision pulse |
| no_resp | input | 1 | No-response pulse |
| pos_vld | input | 1 | Collision/error position valid |
| pos_bits | input | 10 | Collision or error bit index |
| irq | output | 1 | Interrupt request to host, active high |

## Verification
The assertions check the following on every cycle:
- the defaults forced while `en` is low;
- the read clear and the control-write clear when no event competes with them;
- flags that never drop without a clear;
- a CRC event that survives any clear in the same cycle;
- enable bits that do not move on a position clear;
- an interrupt that is never high while the status is empty;
- a lone frame start that does not raise the interrupt.

Some behaviours are shown only by the bench's scenarios:
- the exact band edges of the FIFO test;
- the mapping from enable bits to sources;
- the bit layout of all three registers;
- writes that are ignored;
- the split clear of the two position halves;
- the interrupt rising at the end of a frame.

// File: rtl/rdr_irq_pkg.sv
package rdr_irq_pkg;

  localparam int STS_W      = 8;
  localparam int MSK_W      = 6;
  localparam int BIT_TX     = 7;
  localparam int BIT_RX     = 6;
  localparam int BIT_FIFO   = 5;
  localparam int BIT_CRC    = 4;
  localparam int BIT_PAR    = 3;
  localparam int BIT_FRM    = 2;
  localparam int BIT_COL    = 1;
  localparam int BIT_NORESP = 0;

  // FIFO is outside the comfortable band when below lo or above hi.
  function automatic logic fifo_oob(input int lvl, input int lo, input int hi);
    return (lvl < lo) || (lvl > hi);
  endfunction

  // A flag counts toward the interrupt when it is set and qualified:
  // TX/RX by their end-of-frame marker, the others by their enable bit.
  function automatic logic irq_qual(input logic [STS_W-1:0] sts,
                                    input logic             tx_fin,
                                    input logic             rx_fin,
                                    input logic [MSK_W-1:0] msk);
    return (sts[BIT_TX] & tx_fin) | (sts[BIT_RX] & rx_fin) |
           (|(sts[MSK_W-1:0] & msk));
  endfunction

endpackage

// File: rtl/rdr_irq_status.sv
module rdr_irq_status
  import rdr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [STS_W-1:0] set_vec,
  input  logic             tx_fin_set,
  input  logic             rx_fin_set,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] sts_nxt,
  output logic             tx_fin_q,
  output logic             tx_fin_nxt,
  output logic             rx_fin_q,
  output logic             rx_fin_nxt
);

  // A new set always beats a clear in the same cycle.
  for (genvar i = 0; i < STS_W; i++) begin : g_flag
    assign sts_nxt[i] = en & ((sts_q[i] & ~clr) | set_vec[i]);
  end

  assign tx_fin_nxt = en & ((tx_fin_q & ~clr) | tx_fin_set);
  assign rx_fin_nxt = en & ((rx_fin_q & ~clr) | rx_fin_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      tx_fin_q <= 1'b0;
      rx_fin_q <= 1'b0;
    end else begin
      sts_q    <= sts_nxt;
      tx_fin_q <= tx_fin_nxt;
      rx_fin_q <= rx_fin_nxt;
    end
  end

endmodule

// File: rtl/rdr_irq_colpos.sv
module rdr_irq_colpos
  import rdr_irq_pkg::*;
#(
  parameter int               DATA_W  = 8,
  parameter int               POS_W   = 10,
  parameter logic [MSK_W-1:0] MSK_RST = 6'h3E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             msk_wr,
  input  logic [MSK_W-1:0] msk_wdata,
  input  logic             pos_vld,
  input  logic [POS_W-1:0] pos_bits,
  input  logic             clr_pos_hi,
  input  logic             clr_pos_lo,
  output logic [MSK_W-1:0] msk_q,
  output logic [MSK_W-1:0] msk_nxt,
  output logic [POS_W-1:0] pos_q
);

  localparam int HI_W = POS_W - DATA_W;

  logic [POS_W-1:0] pos_nxt;

  always_comb begin
    if (!en)        msk_nxt = MSK_RST;
    else if (msk_wr) msk_nxt = msk_wdata;
    else            msk_nxt = msk_q;
  end

  always_comb begin
    pos_nxt = pos_q;
    if (!en) begin
      pos_nxt = '0;
    end else if (pos_vld) begin
      pos_nxt = pos_bits;
    end else begin
      if (clr_pos_hi) pos_nxt[POS_W-1:DATA_W] = '0;
      if (clr_pos_lo) pos_nxt[DATA_W-1:0]     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= MSK_RST;
      pos_q <= '0;
    end else begin
      msk_q <= msk_nxt;
      pos_q <= pos_nxt;
    end
  end

  logic unused_hi_w;
  assign unused_hi_w = (HI_W > 0);

endmodule

// File: rtl/rdr_irq_regif.sv
module rdr_irq_regif
  import rdr_irq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter int              POS_W    = 10,
  parameter logic [ADDR_W-1:0] ADDR_STS = 8'h0C,
  parameter logic [ADDR_W-1:0] ADDR_MSK = 8'h0D,
  parameter logic [ADDR_W-1:0] ADDR_POS = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              rd_end,
  input  logic [STS_W-1:0]  sts_q,
  input  logic [MSK_W-1:0]  msk_q,
  input  logic [POS_W-1:0]  pos_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              msk_wr,
  output logic [MSK_W-1:0]  msk_wdata,
  output logic              clr_sts,
  output logic              clr_pos_hi,
  output logic              clr_pos_lo
);

  logic hit_sts, hit_msk, hit_pos;
  logic arm_sts_q, arm_hi_q, arm_lo_q;

  assign hit_sts = reg_rd & (reg_addr == ADDR_STS);
  assign hit_msk = reg_rd & (reg_addr == ADDR_MSK);
  assign hit_pos = reg_rd & (reg_addr == ADDR_POS);

  // Only the enable bits of the mask register are writable.
  assign msk_wr    = en & reg_wr & (reg_addr == ADDR_MSK);
  assign msk_wdata = reg_wdata[MSK_W-1:0];

  // Clear-on-read takes effect at the close of the read phase.
  assign clr_sts    = en & rd_end & (arm_sts_q | hit_sts);
  assign clr_pos_hi = en & rd_end & (arm_hi_q  | hit_msk);
  assign clr_pos_lo = en & rd_end & (arm_lo_q  | hit_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_sts_q <= 1'b0;
      arm_hi_q  <= 1'b0;
      arm_lo_q  <= 1'b0;
    end else if (!en || rd_end) begin
      arm_sts_q <= 1'b0;
      arm_hi_q  <= 1'b0;
      arm_lo_q  <= 1'b0;
    end else begin
      arm_sts_q <= arm_sts_q | hit_sts;
      arm_hi_q  <= arm_hi_q  | hit_msk;
      arm_lo_q  <= arm_lo_q  | hit_pos;
    end
  end

  always_comb begin
    if (reg_addr == ADDR_STS)      reg_rdata = sts_q;
    else if (reg_addr == ADDR_MSK) reg_rdata = {pos_q[POS_W-1:DATA_W], msk_q};
    else if (reg_addr == ADDR_POS) reg_rdata = pos_q[DATA_W-1:0];
    else                           reg_rdata = '0;
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:MSK_W];

endmodule

// File: rtl/rdr_irq_ctrl.sv
module rdr_irq_ctrl
  import rdr_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter int                POS_W    = 10,
  parameter int                LVL_W    = 5,
  parameter int                FIFO_LO  = 4,
  parameter int                FIFO_HI  = 8,
  parameter logic [ADDR_W-1:0] ADDR_STS = 8'h0C,
  parameter logic [ADDR_W-1:0] ADDR_MSK = 8'h0D,
  parameter logic [ADDR_W-1:0] ADDR_POS = 8'h0E,
  parameter logic [MSK_W-1:0]  MSK_RST  = 6'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ctrl_wr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rd_end,
  input  logic              tx_start,
  input  logic              tx_done,
  input  logic              rx_sof,
  input  logic              rx_done,
  input  logic              fifo_upd,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              crc_err,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              col_err,
  input  logic              no_resp,
  input  logic              pos_vld,
  input  logic [POS_W-1:0]  pos_bits,
  output logic              irq
);

  // Named internal events, brought out for the checker.
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] sts_q, sts_nxt;
  logic [MSK_W-1:0] msk_q, msk_nxt, msk_wdata;
  logic [POS_W-1:0] pos_q;
  logic             tx_fin_q, tx_fin_nxt, rx_fin_q, rx_fin_nxt;
  logic             msk_wr, clr_sts, clr_pos_hi, clr_pos_lo;
  logic             fifo_hit, irq_q;

  assign fifo_hit = fifo_upd & fifo_oob(int'(fifo_level), FIFO_LO, FIFO_HI);

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_TX]     = tx_start | tx_done;
    set_vec[BIT_RX]     = rx_sof | rx_done;
    set_vec[BIT_FIFO]   = fifo_hit;
    set_vec[BIT_CRC]    = crc_err;
    set_vec[BIT_PAR]    = par_err;
    set_vec[BIT_FRM]    = frm_err;
    set_vec[BIT_COL]    = col_err;
    set_vec[BIT_NORESP] = no_resp;
  end

  rdr_irq_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POS_W(POS_W),
    .ADDR_STS(ADDR_STS), .ADDR_MSK(ADDR_MSK), .ADDR_POS(ADDR_POS)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .en(en),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_end(rd_end),
    .sts_q(sts_q), .msk_q(msk_q), .pos_q(pos_q),
    .reg_rdata(reg_rdata), .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .clr_sts(clr_sts), .clr_pos_hi(clr_pos_hi), .clr_pos_lo(clr_pos_lo)
  );

  rdr_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .en(en),
    .clr(clr_sts | ctrl_wr),
    .set_vec(set_vec),
    .tx_fin_set(tx_done), .rx_fin_set(rx_done),
    .sts_q(sts_q), .sts_nxt(sts_nxt),
    .tx_fin_q(tx_fin_q), .tx_fin_nxt(tx_fin_nxt),
    .rx_fin_q(rx_fin_q), .rx_fin_nxt(rx_fin_nxt)
  );

  rdr_irq_colpos #(
    .DATA_W(DATA_W), .POS_W(POS_W), .MSK_RST(MSK_RST)
  ) u_colpos (
    .clk(clk), .rst_n(rst_n), .en(en),
    .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .pos_vld(pos_vld), .pos_bits(pos_bits),
    .clr_pos_hi(clr_pos_hi), .clr_pos_lo(clr_pos_lo),
    .msk_q(msk_q), .msk_nxt(msk_nxt), .pos_q(pos_q)
  );

  // Registered interrupt, aligned with the stored flags.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_qual(sts_nxt, tx_fin_nxt, rx_fin_nxt, msk_nxt);
  end

  assign irq = irq_q;

  logic unused_fin_q;
  assign unused_fin_q = tx_fin_q ^ rx_fin_q;

endmodule

// File: rtl/rdr_irq_chk.sv
module rdr_irq_chk
  import rdr_irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                POS_W    = 10,
  parameter logic [ADDR_W-1:0] ADDR_MSK = 8'h0D,
  parameter logic [MSK_W-1:0]  MSK_RST  = 6'h3E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ctrl_wr,
  input logic              tx_done,
  input logic              crc_err,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              irq,
  input logic [STS_W-1:0]  sts_q,
  input logic [MSK_W-1:0]  msk_q,
  input logic [POS_W-1:0]  pos_q,
  input logic              clr_sts,
  input logic              clr_pos_hi,
  input logic [STS_W-1:0]  set_vec
);

  AST_EN_LOW_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sts_q == '0 && !irq && pos_q == '0 && msk_q == MSK_RST)); // R11

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_sts && set_vec == '0) |=> (sts_q == '0 && !irq)); // R7

  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ctrl_wr && set_vec == '0) |=> (sts_q == '0 && !irq)); // R10

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr_sts && !ctrl_wr) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R1

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && crc_err) |=> sts_q[BIT_CRC]); // R12

  AST_MASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_pos_hi && !(reg_wr && reg_addr == ADDR_MSK)) |=> $stable(msk_q)); // R9

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0)); // R13

  AST_TX_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q == '0 && set_vec == 8'h80 && !tx_done) |=> !irq); // R2

endmodule

bind rdr_irq_ctrl rdr_irq_chk #(
  .ADDR_W(ADDR_W), .POS_W(POS_W), .ADDR_MSK(ADDR_MSK), .MSK_RST(MSK_RST)
) u_chk (.*);

// File: tb/tb_rdr_irq_ctrl.sv
module tb_rdr_irq_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic       ctrl_wr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, rd_end = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic       tx_start = 1'b0, tx_done = 1'b0, rx_sof = 1'b0, rx_done = 1'b0;
  logic       fifo_upd = 1'b0;
  logic [4:0] fifo_level = 5'd6;
  logic       crc_err = 1'b0, par_err = 1'b0, frm_err = 1'b0, col_err = 1'b0, no_resp = 1'b0;
  logic       pos_vld = 1'b0;
  logic [9:0] pos_bits = 10'h000;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdr_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ctrl_wr(ctrl_wr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_end(rd_end),
    .tx_start(tx_start), .tx_done(tx_done), .rx_sof(rx_sof), .rx_done(rx_done),
    .fifo_upd(fifo_upd), .fifo_level(fifo_level),
    .crc_err(crc_err), .par_err(par_err), .frm_err(frm_err),
    .col_err(col_err), .no_resp(no_resp),
    .pos_vld(pos_vld), .pos_bits(pos_bits), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    ctrl_wr = 0; reg_wr = 0; reg_rd = 0; rd_end = 0;
    tx_start = 0; tx_done = 0; rx_sof = 0; rx_done = 0; fifo_upd = 0;
    crc_err = 0; par_err = 0; frm_err = 0; col_err = 0; no_resp = 0; pos_vld = 0;
  endtask

  // Look at a register without starting a read phase.
  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // Full read phase: strobe, then end-of-read one cycle later.
  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    reg_rd = 1; reg_addr = a; #1; d = reg_rdata;
    step(); reg_rd = 0; rd_end = 1;
    step(); rd_end = 0;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    step(); reg_wr = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    peek(8'h0C, d); chk("R1", "status after reset", d, 8'h00);
    peek(8'h0D, d); chk("R6", "mask after reset", d, 8'h3E);
    peek(8'h0E, d); chk("R8", "pos low after reset", d, 8'h00);
    chk("R13", "irq after reset", irq, 0);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    tx_start = 1; step(); quiet();
    peek(8'h0C, d); chk("R2", "TX flag at start", d, 8'h80);
    chk("R2", "no irq before TX end", irq, 0);
    step(3); chk("R2", "irq held during TX", irq, 0);
    tx_done = 1; step(); quiet();
    chk("R2", "irq at TX end", irq, 1);
    step(3); chk("R13", "irq stays high", irq, 1);
    host_read(8'h0C, d);
    chk("R1", "status read value", d, 8'h80);
    peek(8'h0C, d); chk("R7", "status cleared after read", d, 8'h00);
    chk("R7", "irq dropped after read", irq, 0);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    rx_sof = 1; step(); quiet();
    peek(8'h0C, d); chk("R3", "RX flag at SOF", d, 8'h40);
    chk("R3", "no irq before RX end", irq, 0);
    rx_done = 1; step(); quiet();
    chk("R3", "irq at RX end", irq, 1);
    host_read(8'h0C, d);
    chk("R7", "irq cleared after RX read", irq, 0);
  endtask

  task automatic t_fifo();
    logic [7:0] d;
    int lv[4] = '{6, 4, 8, 5};
    foreach (lv[i]) begin
      fifo_upd = 1; fifo_level = 5'(lv[i]); step(); quiet();
      peek(8'h0C, d); chk("R4", "in-band level leaves flag", d, 8'h00);
    end
    fifo_upd = 1; fifo_level = 5'd3; step(); quiet();
    peek(8'h0C, d); chk("R4", "level 3 sets FIFO flag", d, 8'h20);
    chk("R5", "FIFO enabled by default", irq, 1);
    host_read(8'h0C, d);
    fifo_upd = 1; fifo_level = 5'd9; step(); quiet();
    peek(8'h0C, d); chk("R4", "level 9 sets FIFO flag", d, 8'h20);
    host_read(8'h0C, d);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    no_resp = 1; step(); quiet();
    peek(8'h0C, d); chk("R5", "no-response flag", d, 8'h01);
    chk("R5", "no-response masked by default", irq, 0);
    host_write(8'h0D, 8'h01);
    chk("R5", "irq after enabling no-response", irq, 1);
    peek(8'h0D, d); chk("R6", "mask write", d, 8'h01);
    host_read(8'h0C, d);
    par_err = 1; step(); quiet();
    chk("R5", "parity masked off", irq, 0);
    host_read(8'h0C, d);
    host_write(8'h0D, 8'hFF);
    peek(8'h0D, d); chk("R6", "mask write ignores 7:6", d, 8'h3F);
    host_write(8'h0C, 8'hFF);
    peek(8'h0C, d); chk("R6", "status write ignored", d, 8'h00);
    host_write(8'h0E, 8'h55);
    peek(8'h0E, d); chk("R6", "pos write ignored", d, 8'h00);
    host_write(8'h0D, 8'h3E);
    par_err = 1; step(); quiet();
    chk("R5", "parity enabled raises irq", irq, 1);
    host_read(8'h0C, d);
  endtask

  task automatic t_pos();
    logic [7:0] d;
    pos_vld = 1; pos_bits = 10'h2A5; step(); quiet();
    peek(8'h0D, d); chk("R8", "pos high in 0D", d, 8'hBE);
    peek(8'h0E, d); chk("R8", "pos low in 0E", d, 8'hA5);
    host_read(8'h0E, d);
    peek(8'h0E, d); chk("R9", "0E cleared after read", d, 8'h00);
    peek(8'h0D, d); chk("R9", "0D untouched by 0E read", d, 8'hBE);
    host_read(8'h0D, d);
    peek(8'h0D, d); chk("R9", "0D pos cleared, mask kept", d, 8'h3E);
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    frm_err = 1; step(); quiet();
    chk("R5", "framing raises irq", irq, 1);
    ctrl_wr = 1; step(); quiet();
    peek(8'h0C, d); chk("R10", "control write clears status", d, 8'h00);
    chk("R10", "control write drops irq", irq, 0);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    crc_err = 1; step(); quiet();
    reg_rd = 1; reg_addr = 8'h0C; step();
    reg_rd = 0; rd_end = 1; col_err = 1; step(); quiet();
    peek(8'h0C, d); chk("R12", "event beats read clear", d, 8'h02);
    chk("R12", "irq kept by new event", irq, 1);
    ctrl_wr = 1; par_err = 1; step(); quiet();
    peek(8'h0C, d); chk("R12", "event beats control clear", d, 8'h08);
    pos_vld = 1; pos_bits = 10'h155; step(); quiet();
    reg_rd = 1; reg_addr = 8'h0E; step();
    reg_rd = 0; rd_end = 1; pos_vld = 1; pos_bits = 10'h0C3; step(); quiet();
    peek(8'h0E, d); chk("R12", "new position beats clear", d, 8'hC3);
    host_read(8'h0C, d); host_read(8'h0E, d); host_read(8'h0D, d);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    host_write(8'h0D, 8'h00);
    tx_done = 1; pos_vld = 1; pos_bits = 10'h3FF; step(); quiet();
    chk("R2", "TX end raises irq with mask 0", irq, 1);
    en = 0; crc_err = 1; reg_wr = 1; reg_addr = 8'h0D; reg_wdata = 8'h00;
    step(2); quiet();
    peek(8'h0C, d); chk("R11", "status while disabled", d, 8'h00);
    peek(8'h0D, d); chk("R11", "0D default while disabled", d, 8'h3E);
    peek(8'h0E, d); chk("R11", "pos while disabled", d, 8'h00);
    chk("R11", "irq while disabled", irq, 0);
    en = 1; step();
    peek(8'h0D, d); chk("R11", "write ignored while disabled", d, 8'h3E);
  endtask

  initial begin
    fork
      begin
        step(2); rst_n = 1; step();
        t_reset(); t_tx(); t_rx(); t_fifo(); t_mask();
        t_pos(); t_ctrl(); t_collide(); t_enable();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          errors++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule